// File: doc/BRIEF.md
# Dual-Space SPI Register Decoder

This block is the SPI slave front end of a radio controller's register file. An external host selects the block with an active-low chip select and clocks commands and data in SPI mode 0. Two separate address spaces sit behind the interface. A short space of 64 byte registers is reached with a one-byte command. A long space of 1024 byte locations is reached with a two-byte command. The first bit received after chip select falls decides which command format follows.

After the command, data bytes stream in or out. The address advances by one after each byte and wraps inside its own space, so a single command can fill or drain a buffer region. All SPI pins are oversampled in the system clock domain, so `clk` must run at least eight times faster than SCLK. Raising chip select ends the transaction at any point and drops any byte that is only partly received. On-chip logic can read either space through a parallel read port.

Top module: `spi_regmap`

## Requirements
- R1: A first byte with bit 7 at 0 is a short command. Bits 6:1 give the register address and bit 0 selects write (1) or read (0).
- R2: A first byte with bit 7 at 1 starts a long command. Over the 16 command bits, bits 14:5 give the address and bit 4 selects write (1) or read (0). Bits 3:0 are ignored.
- R3: In a short write, the byte that follows the command is stored at the addressed short register.
- R4: In a read, the addressed byte is returned on MISO, MSB first, during the byte that immediately follows the command.
- R5: After a long write command, every further data byte sent while chip select stays low is stored at the next consecutive long address.
- R6: After a long read command, successive bytes return consecutive long addresses.
- R7: The address counter wraps within its space: long 0x3FF is followed by 0x000, and short 0x3F is followed by 0x00.
- R8: When chip select rises in the middle of a byte, that partial byte is dropped and writes nothing. The next transaction is decoded from its first bit.
- R9: MISO is low while chip select is high, during command bytes, and throughout write transactions.
- R10: While chip select is low, MISO changes only in response to SCLK falling edges (mode 0).
- R11: The parallel port returns the byte at `par_addr` in the space chosen by `par_long` one clock after those inputs are applied. In the short space, only the low 6 address bits are used.
- R12: The short and long spaces are separate. A write to one never changes the other at the same index.
- R13: Each stored byte produces exactly one single-cycle internal write strobe, and only while chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, low when not selected |
| par_long | input | 1 | Parallel port space select: 1 long, 0 short |
| par_addr | input | 10 | Parallel port read address |
| par_rdata | output | 8 | Parallel port read data, one clock latency |

## Verification
The checker watches properties that hold on every cycle. MISO must fall to zero once chip select is inactive and stay quiet during writes, and it may change only after a synchronized SCLK fall. The write strobe must be a single cycle and must occur only while the block is selected. Directed scenarios supply the rest. These cover command decoding in both formats, burst address sequencing and wrap at both space boundaries, read-data return, aborted partial bytes, and isolation between the two spaces. Each result is checked through the parallel port or by reading back over SPI.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;
  typedef enum logic [1:0] {PH_CMD0, PH_CMD1, PH_DATA} phase_t;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 16;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  logic [STAGES:0]   sclk_q;
  logic [STAGES-1:0] csn_q;
  logic [STAGES-1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk};
      csn_q  <= {csn_q[STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
  assign cs_act    = ~csn_q[STAGES-1];
  assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_regmap_ram.sv
module spi_regmap_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] addr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    rdata_b <= mem[addr_b];
  end
endmodule

// File: rtl/spi_regmap_ctrl.sv
module spi_regmap_ctrl
  import spi_regmap_pkg::*;
#(
  parameter int SHORT_AW = 6,
  parameter int LONG_AW  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               cs_act,
  input  logic               mosi_s,
  input  logic [BYTE_W-1:0]  rdata,
  output logic               mem_we,
  output logic               mem_long,
  output logic [LONG_AW-1:0] mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  output logic               miso
);
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int L_SHIFT = CMD_W - 1 - LONG_AW;

  phase_t              phase;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-2:0]   rx_sh;
  logic [BYTE_W-1:0]   rx_next;
  logic [BYTE_W-2:0]   hi_bits;
  logic                is_long;
  logic                is_wr;
  logic [LONG_AW-1:0]  addr;
  logic [LONG_AW-1:0]  addr_inc;
  logic [SHORT_AW-1:0] short_inc;
  logic [BYTE_W-1:0]   tx_sh;
  logic                we_q;
  logic [LONG_AW-1:0]  waddr_q;
  logic [BYTE_W-1:0]   wdata_q;

  assign rx_next   = {rx_sh, mosi_s};
  assign short_inc = addr[SHORT_AW-1:0] + SHORT_AW'(1);
  assign addr_inc  = is_long ? addr + LONG_AW'(1) : LONG_AW'(short_inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CMD0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      hi_bits <= '0;
      is_long <= 1'b0;
      is_wr   <= 1'b0;
      addr    <= '0;
      tx_sh   <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_CMD0;
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else if (sclk_rise) begin
        rx_sh   <= rx_next[BYTE_W-2:0];
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == CNT_W'(BYTE_W-1)) begin
          unique case (phase)
            PH_CMD0: begin
              if (rx_next[BYTE_W-1]) begin
                hi_bits <= rx_next[BYTE_W-2:0];
                is_long <= 1'b1;
                phase   <= PH_CMD1;
              end else begin
                is_long <= 1'b0;
                is_wr   <= rx_next[0];
                addr    <= LONG_AW'(rx_next[BYTE_W-2 -: SHORT_AW]);
                phase   <= PH_DATA;
              end
            end
            PH_CMD1: begin
              addr  <= LONG_AW'({hi_bits, rx_next} >> L_SHIFT);
              is_wr <= rx_next[L_SHIFT-1];
              phase <= PH_DATA;
            end
            default: begin
              if (is_wr) begin
                we_q    <= 1'b1;
                waddr_q <= addr;
                wdata_q <= rx_next;
              end
              addr <= addr_inc;
            end
          endcase
        end
      end else if (sclk_fall) begin
        if (phase == PH_DATA && bit_cnt == '0 && !is_wr) tx_sh <= rdata;
        else tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_long  = is_long;
  assign mem_addr  = we_q ? waddr_q : addr;
  assign mem_wdata = wdata_q;
  assign miso      = tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_regmap.sv
module spi_regmap
  import spi_regmap_pkg::*;
#(
  parameter int SHORT_AW    = 6,
  parameter int LONG_AW     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic               par_long,
  input  logic [LONG_AW-1:0] par_addr,
  output logic [BYTE_W-1:0]  par_rdata
);
  logic               sclk_rise, sclk_fall, cs_act, mosi_s;
  logic               mem_we, mem_long;
  logic [LONG_AW-1:0] mem_addr;
  logic [BYTE_W-1:0]  mem_wdata, short_rd, long_rd, short_b, long_b;
  logic               par_long_q;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_regmap_ctrl #(.SHORT_AW(SHORT_AW), .LONG_AW(LONG_AW)) u_ctrl (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s),
    .rdata(mem_long ? long_rd : short_rd),
    .mem_we(mem_we), .mem_long(mem_long), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .miso(spi_miso)
  );

  spi_regmap_ram #(.AW(SHORT_AW), .DW(BYTE_W)) u_short (
    .clk(clk), .we(mem_we & ~mem_long), .addr(mem_addr[SHORT_AW-1:0]),
    .wdata(mem_wdata), .rdata(short_rd),
    .addr_b(par_addr[SHORT_AW-1:0]), .rdata_b(short_b)
  );

  spi_regmap_ram #(.AW(LONG_AW), .DW(BYTE_W)) u_long (
    .clk(clk), .we(mem_we & mem_long), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(long_rd),
    .addr_b(par_addr), .rdata_b(long_b)
  );

  always_ff @(posedge clk) begin
    if (rst) par_long_q <= 1'b0;
    else     par_long_q <= par_long;
  end

  assign par_rdata = par_long_q ? long_b : short_b;
endmodule

// File: rtl/spi_regmap_chk.sv
module spi_regmap_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic sclk_fall,
  input logic mem_we,
  input logic miso
);
  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

  // R9
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !miso);

  // R10
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sclk_fall) |=> $stable(miso));

  // R13
  we_sel_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(cs_act));

  // R13
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind spi_regmap spi_regmap_chk i_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .mem_we(mem_we), .miso(spi_miso)
);

// File: tb/test_spi_regmap.sv
module test_spi_regmap;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic       par_long = 1'b0;
  logic [9:0] par_addr = '0;
  logic [7:0] par_rdata;
  int         errors = 0;
  int         checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regmap i_spi_regmap (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .par_long(par_long), .par_addr(par_addr), .par_rdata(par_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] short_cmd(input logic [5:0] a, input logic wr);
    return {1'b0, a, wr};
  endfunction

  function automatic logic [15:0] long_cmd(input logic [9:0] a, input logic wr, input logic [3:0] dc);
    return {1'b1, a, wr, dc};
  endfunction

  task automatic spi_begin();
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic spi_end();
    #(HALF);
    cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      #(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic par_read(input logic lng, input logic [9:0] a, output logic [7:0] d);
    par_long = lng;
    par_addr = a;
    #(2*CLK_PERIOD);
    d = par_rdata;
  endtask

  task automatic short_write(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] rx;
    spi_begin();
    spi_byte(short_cmd(a, 1'b1), rx);
    spi_byte(d, rx);
    spi_end();
  endtask

  task automatic t_reset();
    chk("R9 reset miso", {7'b0, miso}, 8'h00);
  endtask

  task automatic t_short_write();
    logic [7:0] d;
    short_write(6'h15, 8'hA5);
    par_read(1'b0, 10'h015, d);
    chk("R1 R3 R11 R13 short write", d, 8'hA5);
  endtask

  task automatic t_short_read();
    logic [7:0] rc, rd;
    spi_begin();
    spi_byte(short_cmd(6'h15, 1'b0), rc);
    spi_byte(8'h00, rd);
    spi_end();
    chk("R9 miso during command", rc, 8'h00);
    chk("R4 R10 short read data", rd, 8'hA5);
  endtask

  task automatic t_long_burst_write();
    logic [7:0] rx, d;
    logic [15:0] c;
    c = long_cmd(10'h123, 1'b1, 4'hA);
    spi_begin();
    spi_byte(c[15:8], rx);
    spi_byte(c[7:0], rx);
    for (int k = 0; k < 4; k++) spi_byte(8'hC0 + 8'(k), rx);
    spi_end();
    for (int k = 0; k < 4; k++) begin
      par_read(1'b1, 10'h123 + 10'(k), d);
      chk("R2 R5 long burst write", d, 8'hC0 + 8'(k));
    end
  endtask

  task automatic t_long_burst_read();
    logic [7:0] rx;
    logic [15:0] c;
    c = long_cmd(10'h123, 1'b0, 4'h5);
    spi_begin();
    spi_byte(c[15:8], rx);
    spi_byte(c[7:0], rx);
    for (int k = 0; k < 4; k++) begin
      spi_byte(8'hFF, rx);
      chk("R6 long burst read", rx, 8'hC0 + 8'(k));
    end
    spi_end();
  endtask

  task automatic t_long_wrap();
    logic [7:0] rx, d;
    logic [15:0] c;
    c = long_cmd(10'h3FF, 1'b1, 4'h0);
    spi_begin();
    spi_byte(c[15:8], rx);
    spi_byte(c[7:0], rx);
    spi_byte(8'h11, rx);
    spi_byte(8'h22, rx);
    spi_end();
    par_read(1'b1, 10'h3FF, d);
    chk("R7 long wrap last", d, 8'h11);
    par_read(1'b1, 10'h000, d);
    chk("R7 long wrap first", d, 8'h22);
  endtask

  task automatic t_short_wrap();
    logic [7:0] rx, d;
    spi_begin();
    spi_byte(short_cmd(6'h3F, 1'b1), rx);
    spi_byte(8'h66, rx);
    spi_byte(8'h77, rx);
    spi_end();
    par_read(1'b0, 10'h03F, d);
    chk("R7 short wrap last", d, 8'h66);
    par_read(1'b0, 10'h000, d);
    chk("R7 short wrap first", d, 8'h77);
  endtask

  task automatic t_abort();
    logic [7:0] rx, d;
    short_write(6'h05, 8'h5A);
    spi_begin();
    spi_byte(short_cmd(6'h05, 1'b1), rx);
    spi_bits(8'hFF, 5, rx);
    spi_end();
    par_read(1'b0, 10'h005, d);
    chk("R8 partial byte dropped", d, 8'h5A);
    spi_begin();
    spi_byte(short_cmd(6'h05, 1'b0), rx);
    spi_byte(8'h00, rx);
    spi_end();
    chk("R8 fresh decode after abort", rx, 8'h5A);
  endtask

  task automatic t_separate();
    logic [7:0] rx, d;
    logic [15:0] c;
    c = long_cmd(10'h015, 1'b1, 4'h3);
    spi_begin();
    spi_byte(c[15:8], rx);
    spi_byte(c[7:0], rx);
    spi_byte(8'h3C, rx);
    spi_end();
    par_read(1'b0, 10'h015, d);
    chk("R12 short untouched", d, 8'hA5);
    par_read(1'b1, 10'h015, d);
    chk("R12 long written", d, 8'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(6*CLK_PERIOD);
    rst = 1'b0;
    #(4*CLK_PERIOD);
    t_reset();
    t_short_write();
    t_short_read();
    t_long_burst_write();
    t_long_burst_read();
    t_long_wrap();
    t_short_wrap();
    t_abort();
    t_separate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule